// File: doc/BRIEF.md
# Byte-Oriented I2C Master Write Engine

This block is a master-only I2C transmitter for a small processor. Software controls it through four byte-wide registers. It first puts the destination address, with a write direction bit of 0 in the LSB, into the data register. It then issues a start command to the status register. The engine drives a START and clocks the address byte out MSB first. In acknowledge mode it adds a ninth clock on which it samples the slave's answer.

After each byte the engine parks with SCL held low. A new write to the data register clocks out the next byte by itself. A stop command releases the bus with a STOP condition. Both lines are open-drain and appear as drive-low enables. The half-bit period comes from a divider of the system clock, with one count for the standard rate and one for the fast rate.

Register map (2-bit address): 0 = data/shift register, 1 = status/command, 2 = control, 3 = clock setup.

Top module: `i2cm_tx_top`

## Requirements
- R1: After reset, every register reads 0x00, both drive-low enables are 0 and irq is 0.
- R2: Writing 0xF0 to address 1 while control bit 3 is 1 and the bus is idle does three things. SDA falls while SCL is high. The data register's byte then goes out MSB first, with one bit per SCL high phase. In acknowledge mode a ninth SCL pulse follows. Status bit 7 (master) and bit 5 (busy) then read 1.
- R3: While control bit 3 is 0, writing 0xF0 produces no SCL or SDA activity and busy stays 0.
- R4: While the engine is parked after a byte, a data-register write clocks out that byte. A data-register write made while a byte is moving is ignored, and the register reads back the byte being sent.
- R5: At the end of the acknowledge clock, status bit 0 takes the SDA level (0 = ACK, 1 = NACK). Status bit 4 (pending) and irq go to 1 at the same time. Any status-register write clears them, and so does launching the next byte.
- R6: With clock-setup bit 1 at 1 (no acknowledge clock), a byte uses exactly 8 SCL pulses, and pending is set after the eighth.
- R7: Clock-setup bit 0 selects the length of each SCL high and low phase. At 0 it is STD_HALF system cycles; at 1 it is FAST_HALF.
- R8: Control bits 2:0 form a bit counter. A START sets it to 0. It advances by one at the end of each data bit's high phase and wraps to 0 when the byte completes.
- R9: Writing 0xD0 while parked makes SDA rise while SCL is high. Both lines are then released and busy reads 0.
- R10: Writing 0x00 to address 1 while idle clears the master bit. While idle, a data-register write only loads the register and reads back.
- R11: A 0xF0 write while parked after a byte is ignored: no new START occurs and no clock pulses follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request, follows the pending bit |

## Verification
A bus monitor decodes START, STOP and every SCL rising edge. A modelled slave pulls SDA low on the acknowledge clock when told to.

The whole 256-value byte space goes out in fast acknowledge mode, with the slave's answer alternating. This separates bit-order and rotation faults from acknowledge-sampling faults.

Separate single transfers cover the standard rate, the no-acknowledge mode, a disabled start, a start issued while the bus is held, and a write that lands mid-byte. The measured SCL high width tells the two rate settings apart. A mid-byte read of the bit counter exposes wrong count points.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_BLO,
        ST_BHI,
        ST_ALO,
        ST_AHI,
        ST_HOLD,
        ST_P1,
        ST_P2
    } eng_state_e;

    localparam logic [1:0] RA_DATA = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_CTRL = 2'd2;
    localparam logic [1:0] RA_CLK  = 2'd3;

    localparam logic [7:0] CMD_START = 8'hF0;
    localparam logic [7:0] CMD_STOP  = 8'hD0;
    localparam logic [7:0] CMD_INIT  = 8'h00;

    typedef struct packed {
        logic       stat_wr;
        logic       start;
        logic       stop;
        logic       init;
        logic       data_wr;
        logic [7:0] data;
    } cmd_t;

    typedef struct packed {
        logic en;
        logic fast;
        logic noack;
    } cfg_t;

    typedef struct packed {
        logic       mst;
        logic       busy;
        logic       pend;
        logic       nack;
        logic [2:0] bitc;
        logic [7:0] shreg;
    } stat_t;

    function automatic logic pulls_scl(eng_state_e s);
        return (s == ST_BLO) || (s == ST_ALO) || (s == ST_HOLD) || (s == ST_P1);
    endfunction

    function automatic logic [7:0] status_byte(stat_t s);
        return {s.mst, 1'b0, s.busy, s.pend, 3'b000, s.nack};
    endfunction

endpackage

// File: rtl/i2cm_halfbit.sv
module i2cm_halfbit #(
    parameter int STD_HALF  = 250,
    parameter int FAST_HALF = 63
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int MAXH = (STD_HALF > FAST_HALF) ? STD_HALF : FAST_HALF;
    localparam int CW   = $clog2(MAXH + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = fast ? CW'(FAST_HALF - 1) : CW'(STD_HALF - 1);
    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= lim;
        end else if (cnt == '0) begin
            cnt <= lim;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R7
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);

endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    input  stat_t      st,
    output cmd_t       cmd,
    output cfg_t       cfg,
    output logic [7:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_CTRL) begin
                cfg.en <= wr_data[3];
            end
            if (wr_addr == RA_CLK) begin
                cfg.fast  <= wr_data[0];
                cfg.noack <= wr_data[1];
            end
        end
    end

    always_comb begin
        cmd.stat_wr = wr_en && (wr_addr == RA_STAT);
        cmd.start   = cmd.stat_wr && (wr_data == CMD_START);
        cmd.stop    = cmd.stat_wr && (wr_data == CMD_STOP);
        cmd.init    = cmd.stat_wr && (wr_data == CMD_INIT);
        cmd.data_wr = wr_en && (wr_addr == RA_DATA);
        cmd.data    = wr_data;
    end

    always_comb begin
        unique case (rd_addr)
            RA_DATA: rd_data = st.shreg;
            RA_STAT: rd_data = status_byte(st);
            RA_CTRL: rd_data = {4'b0000, cfg.en, st.bitc};
            default: rd_data = {6'b000000, cfg.noack, cfg.fast};
        endcase
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  cfg_t cfg,
    input  logic tick,
    input  logic sda_in,
    output logic run,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output stat_t st
);
    eng_state_e              state;
    logic [7:0]              shreg;
    logic [2:0]              bitc;
    logic                    nack;
    logic                    pend;
    logic                    mst;
    logic [SYNC_STAGES-1:0]  sync;
    logic                    sda_s;

    assign sda_s = sync[SYNC_STAGES-1];
    assign run   = (state != ST_IDLE) && (state != ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= '1;
        end else begin
            sync <= {sync[SYNC_STAGES-2:0], sda_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            shreg <= '0;
            bitc  <= '0;
            nack  <= 1'b0;
            pend  <= 1'b0;
            mst   <= 1'b0;
        end else begin
            if (cmd.stat_wr) begin
                pend <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    if (cmd.data_wr) begin
                        shreg <= cmd.data;
                    end
                    if (cmd.init) begin
                        mst <= 1'b0;
                    end else if (cmd.start && cfg.en) begin
                        state <= ST_START;
                        mst   <= 1'b1;
                        bitc  <= '0;
                    end
                end
                ST_START: if (tick) state <= ST_BLO;
                ST_BLO:   if (tick) state <= ST_BHI;
                ST_BHI: begin
                    if (tick) begin
                        shreg <= {shreg[6:0], shreg[7]};
                        bitc  <= bitc + 3'd1;
                        if (bitc == 3'd7) begin
                            if (cfg.noack) begin
                                state <= ST_HOLD;
                                pend  <= 1'b1;
                            end else begin
                                state <= ST_ALO;
                            end
                        end else begin
                            state <= ST_BLO;
                        end
                    end
                end
                ST_ALO: if (tick) state <= ST_AHI;
                ST_AHI: begin
                    if (tick) begin
                        nack  <= sda_s;
                        pend  <= 1'b1;
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (cmd.stop) begin
                        state <= ST_P1;
                    end else if (cmd.data_wr) begin
                        shreg <= cmd.data;
                        pend  <= 1'b0;
                        state <= ST_BLO;
                    end
                end
                ST_P1:   if (tick) state <= ST_P2;
                ST_P2:   if (tick) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_START, ST_P1, ST_P2: sda_drive_low = 1'b1;
            ST_BLO, ST_BHI:         sda_drive_low = ~shreg[7];
            default:                sda_drive_low = 1'b0;
        endcase
    end

    assign scl_drive_low = pulls_scl(state);

    always_comb begin
        st.mst   = mst;
        st.busy  = (state != ST_IDLE);
        st.pend  = pend;
        st.nack  = nack;
        st.bitc  = bitc;
        st.shreg = shreg;
    end

    // R8
    hold_bitc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> (bitc == 3'd0));

    // R4
    bit_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BHI && $past(state) == ST_BHI) |-> $stable(sda_drive_low));

    // R5
    pend_on_clock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(tick));

    // R3
    start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mst) |-> $past(cfg.en));

endmodule

// File: rtl/i2cm_tx_top.sv
module i2cm_tx_top
    import i2cm_pkg::*;
#(
    parameter int STD_HALF    = 250,
    parameter int FAST_HALF   = 63,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       irq
);
    cmd_t  cmd;
    cfg_t  cfg;
    stat_t st;
    logic  run;
    logic  tick;

    i2cm_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .st      (st),
        .cmd     (cmd),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    i2cm_halfbit #(
        .STD_HALF  (STD_HALF),
        .FAST_HALF (FAST_HALF)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .fast (cfg.fast),
        .tick (tick)
    );

    i2cm_engine #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_eng (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .cfg           (cfg),
        .tick          (tick),
        .sda_in        (sda_in),
        .run           (run),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .st            (st)
    );

    assign irq = st.pend;

endmodule

// File: tb/test_i2cm_tx_top.sv
module test_i2cm_tx_top;
    localparam int STDH  = 10;
    localparam int FASTH = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       scl_drive_low, sda_drive_low, irq;
    logic       pull = 1'b0;
    logic       sda_w, scl_w;

    int n_tests = 0, n_fail = 0;
    int rises = 0, starts = 0, stops = 0, base = 0;
    int hcnt = 0, last_high = 0;
    logic [15:0] hist = '0;
    logic pscl = 1'b1, psda = 1'b1;
    logic ack_en = 1'b0, ackmode = 1'b1, done = 1'b0;

    always #5 clk = ~clk;

    assign scl_w = ~scl_drive_low;
    assign sda_w = ~(sda_drive_low | pull);

    i2cm_tx_top #(.STD_HALF(STDH), .FAST_HALF(FASTH)) i_i2cm_tx_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sda_in(sda_w),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .irq(irq));

    // bus monitor and slave model
    always @(negedge clk) begin
        if (scl_w && pscl && psda && !sda_w) starts <= starts + 1;
        if (scl_w && pscl && !psda && sda_w) stops <= stops + 1;
        if (scl_w && !pscl) begin
            rises <= rises + 1;
            hist  <= {hist[14:0], sda_w};
            hcnt  <= 1;
        end else if (scl_w) begin
            hcnt <= hcnt + 1;
        end
        if (!scl_w && pscl) last_high <= hcnt;
        if (!scl_w) pull <= ack_en && ackmode && (rises - base == 8);
        pscl <= scl_w;
        psda <= sda_w;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
        #1;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int s0, r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wait_cycles(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk(d == 8'h00, "R1 register reset", d, 0);
        end
        chk({scl_drive_low, sda_drive_low, irq} == 3'b000, "R1 lines/irq", {scl_drive_low, sda_drive_low, irq}, 0);

        // R10 idle load, R3 disabled start
        wr(2'd0, 8'hA4);
        rd(2'd0, d);
        chk(d == 8'hA4, "R10 idle data load", d, 8'hA4);
        r0 = rises; s0 = starts;
        wr(2'd1, 8'hF0);
        wait_cycles(60);
        rd(2'd1, d);
        chk(d[5] == 1'b0 && rises == r0 && starts == s0, "R3 start while disabled", {d, 8'(rises - r0)}, 0);

        // R2 start + address, standard rate, ack mode
        wr(2'd2, 8'h08);
        wr(2'd3, 8'h00);
        ackmode = 1'b1; ack_en = 1'b1; base = rises; s0 = starts;
        wr(2'd1, 8'hF0);
        wait_irq();
        chk(starts == s0 + 1, "R2 start condition", starts - s0, 1);
        chk(rises - base == 9 && hist[8:1] == 8'hA4, "R2 address byte", {hist[8:1], 8'(rises - base)}, {8'hA4, 8'd9});
        chk(last_high == STDH, "R7 standard high phase", last_high, STDH);
        rd(2'd1, d);
        chk(d == 8'hB0, "R5 status after ack (master,busy,pending,ack)", d, 8'hB0);
        chk(irq == 1'b1, "R5 irq set", irq, 1);

        // R5 clear by status write
        wr(2'd1, 8'h00);
        rd(2'd1, d);
        chk(d == 8'hA0 && !irq, "R5 pending cleared", d, 8'hA0);

        // R11 start while parked
        r0 = rises; s0 = starts;
        wr(2'd1, 8'hF0);
        wait_cycles(60);
        chk(rises == r0 && starts == s0, "R11 start while parked", rises - r0, 0);

        // R4, R8 data byte with NACK, write during transfer
        ack_en = 1'b0; base = rises;
        wr(2'd0, 8'h5A);
        for (int i = 0; i < 2000 && !(rises - base == 4 && !scl_w); i++) begin
            @(negedge clk); #1;
        end
        rd(2'd2, d);
        chk(d == 8'h0C, "R8 bit counter mid byte", d, 8'h0C);
        wr(2'd0, 8'hFF);
        wait_irq();
        chk(hist[8:1] == 8'h5A && rises - base == 9, "R4 data byte", hist[8:1], 8'h5A);
        rd(2'd0, d);
        chk(d == 8'h5A, "R4 write during byte ignored", d, 8'h5A);
        rd(2'd1, d);
        chk(d[0] == 1'b1, "R5 nack sampled", d[0], 1);
        rd(2'd2, d);
        chk(d[2:0] == 3'd0, "R8 bit counter wraps", d[2:0], 0);

        // R9 stop
        s0 = stops;
        wr(2'd1, 8'hD0);
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, d);
            if (!d[5]) break;
            @(negedge clk);
        end
        chk(stops == s0 + 1 && !scl_drive_low && !sda_drive_low, "R9 stop condition", stops - s0, 1);
        rd(2'd1, d);
        chk(d[5] == 1'b0, "R9 busy clear", d[5], 0);
        wr(2'd1, 8'h00);
        rd(2'd1, d);
        chk(d[7] == 1'b0, "R10 init clears master", d[7], 0);

        // R6 fast, no ack clock
        wr(2'd3, 8'h03);
        ackmode = 1'b0; base = rises;
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hF0);
        wait_irq();
        chk(rises - base == 8 && hist[7:0] == 8'h3C, "R6 eight pulses", {hist[7:0], 8'(rises - base)}, {8'h3C, 8'd8});
        chk(last_high == FASTH, "R7 fast high phase", last_high, FASTH);

        // sweep all byte values, fast rate with ack clock
        wr(2'd3, 8'h01);
        ackmode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            base = rises; ack_en = v[0];
            wr(2'd0, 8'(v));
            wait_irq();
            chk(hist[8:1] == 8'(v) && rises - base == 9, "R4 sweep byte", hist[8:1], v);
            rd(2'd1, d);
            chk(d[0] == ~v[0], "R5 sweep ack bit", d[0], ~v[0]);
        end
        wr(2'd1, 8'hD0);
        wait_cycles(40);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule